// File: doc/BRIEF.md
# DMA Channel Interrupt Status Hub

This block gathers the completion events of up to eight DMA channels into one status word and drives a single interrupt line toward the processor. Each channel reports three kinds of event, error, abort and terminal count, as one-cycle pulses. Each pulse latches a sticky flag. The flags of each event class occupy their own byte lane of the status word, and the bit within the lane is the channel number. Software reads the word and clears flags by writing ones to them.

Each channel has a small control word that holds its enable bit and three suppression bits, one per event class. The hub drives the enable bits out to the channels and shows them all together in a read-only summary word. Writing a channel bit mask to the abort word sends a one-cycle abort request to the selected channels. A small state machine per channel tracks whether the channel is off (`CH_OFF`), running with no flag pending (`CH_RUN`), or halted with at least one flag set (`CH_HALT`). Its transitions are: `CH_OFF`→`CH_RUN` when enabled with no flag; `CH_OFF`→`CH_HALT` when enabled with a flag; `CH_RUN`→`CH_OFF` when disabled; `CH_RUN`→`CH_HALT` when a flag appears; `CH_HALT`→`CH_RUN` or `CH_OFF` once all its flags are clear, depending on the enable bit.

Top module: `dma_irq_hub`

## Requirements
- R1: Error flags sit in status bits 7:0, at the bit position equal to the channel number.
- R2: Abort flags sit in status bits 15:8, at 8 plus the channel number.
- R3: Terminal-count flags sit in status bits 23:16, at 16 plus the channel number. Status bits 31:24 always read 0.
- R4: An event pulse sets its flag on the next clock edge. The flag is set even when its interrupt is suppressed.
- R5: A write to word address 0 clears every status bit written with 1. Bits written with 0 are left unchanged.
- R6: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The control word of channel c is at word address 8+c. Bit 0 is enable, bit 1 suppresses error, bit 2 suppresses abort and bit 3 suppresses terminal count. After reset the enable bit is 0 and the three suppression bits are 1.
- R8: `irq` is 1 exactly when some status flag is set and its suppression bit is 0. It follows the status word within the same cycle.
- R9: A write to word address 2 drives `abort_req` with data bits 7:0 for the single following cycle. Otherwise `abort_req` is 0, and word 2 reads 0.
- R10: Word address 1 reads the enable bits of all channels, channel c at bit c. Writes to it have no effect. `ch_en` outputs the same bits.
- R11: `ch_running[c]` is 1 only in `CH_RUN`: the channel is enabled and none of its three flags is set. It updates one cycle after the enable or flag change.
- R12: After reset the status word, `irq`, `abort_req`, `ch_en` and `ch_running` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_err | input | 8 | Per-channel error pulse |
| evt_abt | input | 8 | Per-channel abort-done pulse |
| evt_tc | input | 8 | Per-channel terminal-count pulse |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Combined interrupt |
| abort_req | output | 8 | One-cycle abort request per channel |
| ch_en | output | 8 | Channel enable bits |
| ch_running | output | 8 | Channel in progress (`CH_RUN`) |

## Verification
A flag register that latches into the wrong lane, or that misses a same-cycle event, shows up on `reg_rdata` one edge after the pulse. The same flag appears in `irq` in that same cycle. A suppression bit decoded from the wrong control bit also shows on `irq` at once. A channel state machine stuck in the wrong state shows on `ch_running` one edge after the status or enable change that should have moved it.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int unsigned WORD_STATUS = 0;
    localparam int unsigned WORD_ENSUM  = 1;
    localparam int unsigned WORD_ABORT  = 2;
    localparam int unsigned WORD_CTRL   = 8;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HALT = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   evt_err,
    input  logic [NCH-1:0]   evt_abt,
    input  logic [NCH-1:0]   evt_tc,
    input  logic             clr_en,
    input  logic [3*NCH-1:0] clr_bits,
    output logic [3*NCH-1:0] flags
);
    localparam int FW = 3 * NCH;

    logic [FW-1:0] evt_all;
    assign evt_all = {evt_tc, evt_abt, evt_err};

    // one register per lane so each event class stays in its own byte
    for (genvar k = 0; k < 3; k++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[k*NCH +: NCH] <= '0;
            end else begin
                flags[k*NCH +: NCH] <= (flags[k*NCH +: NCH]
                                        & ~(clr_en ? clr_bits[k*NCH +: NCH] : '0))
                                       | evt_all[k*NCH +: NCH];
            end
        end
    end

    // R4: a pulse always latches its flag
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_all) |=> ((flags & $past(evt_all)) == $past(evt_all)));
    // R5: cleared bits with no competing event are gone
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((flags & $past(clr_bits) & ~$past(evt_all)) == '0));
    // R5: quiet cycle keeps the word
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && evt_all == '0) |=> $stable(flags));
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic any_flag,
    output logic running
);
    chan_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_OFF:  if (en) state_nx = any_flag ? CH_HALT : CH_RUN;
            CH_RUN:  if (!en) state_nx = CH_OFF;
                     else if (any_flag) state_nx = CH_HALT;
            CH_HALT: if (!any_flag) state_nx = en ? CH_RUN : CH_OFF;
            default: state_nx = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        running = (state == CH_RUN);
    end

    // R11: a pending flag never leaves the channel running
    p_halt_on_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (any_flag && en) |=> (state != CH_RUN));
    // R11: a disabled channel stops running
    p_off_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !running);
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_err,
    input  logic [NCH-1:0]    evt_abt,
    input  logic [NCH-1:0]    evt_tc,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [NCH-1:0]    abort_req,
    output logic [NCH-1:0]    ch_en,
    output logic [NCH-1:0]    ch_running
);
    localparam int FW    = 3 * NCH;
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [FW-1:0]  flags;
    logic [FW-1:0]  sup_vec;
    logic [NCH-1:0] sup_err, sup_abt, sup_tc;
    logic           ctrl_sel;
    logic [IDX_W-1:0] ctrl_idx;

    assign ctrl_sel = (int'(reg_addr) >= WORD_CTRL) && (int'(reg_addr) < WORD_CTRL + NCH);
    assign ctrl_idx = IDX_W'(int'(reg_addr) - WORD_CTRL);

    dma_irq_flags #(.NCH(NCH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_err  (evt_err),
        .evt_abt  (evt_abt),
        .evt_tc   (evt_tc),
        .clr_en   (reg_wr && int'(reg_addr) == WORD_STATUS),
        .clr_bits (reg_wdata[FW-1:0]),
        .flags    (flags)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_en[c]   <= 1'b0;
                sup_err[c] <= 1'b1;
                sup_abt[c] <= 1'b1;
                sup_tc[c]  <= 1'b1;
            end else if (reg_wr && ctrl_sel && ctrl_idx == IDX_W'(c)) begin
                ch_en[c]   <= reg_wdata[0];
                sup_err[c] <= reg_wdata[1];
                sup_abt[c] <= reg_wdata[2];
                sup_tc[c]  <= reg_wdata[3];
            end
        end

        dma_irq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[c]),
            .any_flag (flags[c] | flags[NCH + c] | flags[2*NCH + c]),
            .running  (ch_running[c])
        );
    end

    assign sup_vec = {sup_tc, sup_abt, sup_err};
    assign irq     = |(flags & ~sup_vec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            abort_req <= '0;
        else if (reg_wr && int'(reg_addr) == WORD_ABORT)
            abort_req <= reg_wdata[NCH-1:0];
        else
            abort_req <= '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == WORD_STATUS)
            reg_rdata[FW-1:0] = flags;
        else if (int'(reg_addr) == WORD_ENSUM)
            reg_rdata[NCH-1:0] = ch_en;
        else if (ctrl_sel)
            reg_rdata[3:0] = {sup_tc[ctrl_idx], sup_abt[ctrl_idx],
                              sup_err[ctrl_idx], ch_en[ctrl_idx]};
    end

    // R8: interrupt implies a pending flag
    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
    // R9: abort request lasts one cycle without a new write
    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req != '0 && !(reg_wr && int'(reg_addr) == WORD_ABORT)) |=> (abort_req == '0));
    // R9: abort write forwards the mask
    p_abort_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) == WORD_ABORT) |=> (abort_req == $past(reg_wdata[NCH-1:0])));
endmodule

// File: tb/dma_irq_hub_tb.sv
module dma_irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_err = '0, evt_abt = '0, evt_tc = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  abort_req, ch_en, ch_running;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_irq_hub u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_err(evt_err), .evt_abt(evt_abt), .evt_tc(evt_tc),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .abort_req(abort_req),
        .ch_en(ch_en), .ch_running(ch_running)
    );

    // {err, abt, tc, clear[23:0], expected status[23:0]}
    localparam logic [71:0] VEC [7] = '{
        {8'h01, 8'h00, 8'h00, 24'h000000, 24'h000001},
        {8'h00, 8'h80, 8'h10, 24'h000000, 24'h108001},
        {8'h00, 8'h00, 8'h00, 24'h000001, 24'h108000},
        {8'h00, 8'h00, 8'h10, 24'h100000, 24'h108000},
        {8'h0F, 8'h00, 8'h00, 24'h008000, 24'h10000F},
        {8'h00, 8'h00, 8'h02, 24'h00000A, 24'h120005},
        {8'h00, 8'h00, 8'h00, 24'hFFFFFF, 24'h000000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        rd(4'd0, d); check("R12 status", d, 32'h0);
        check("R12 irq", {31'h0, irq}, 32'h0);
        check("R12 abort/en/run", {8'h0, abort_req, ch_en, ch_running}, 32'h0);
        rd(4'd11, d); check("R7 ctrl reset", d, 32'h0000000E);

        // table: R1 R2 R3 R4 R5 R6, masks all set so irq stays low
        for (int i = 0; i < 7; i++) begin
            evt_err = VEC[i][71:64]; evt_abt = VEC[i][63:56]; evt_tc = VEC[i][55:48];
            reg_addr = 4'd0;
            reg_wr = (VEC[i][47:24] != 0);
            reg_wdata = {8'hFF, VEC[i][47:24]};
            @(posedge clk); @(negedge clk);
            evt_err = '0; evt_abt = '0; evt_tc = '0; reg_wr = 1'b0; reg_wdata = '0;
            rd(4'd0, d);
            check($sformatf("R1/R2/R3/R5/R6 step %0d", i), d, {8'h00, VEC[i][23:0]});
            check($sformatf("R4 suppressed irq step %0d", i), {31'h0, irq}, 32'h0);
        end

        // R7/R10: enable ch3 with tc unsuppressed
        wr(4'd11, 32'h7);
        rd(4'd11, d); check("R7 ctrl readback", d, 32'h7);
        rd(4'd1, d);  check("R10 enable summary", d, 32'h08);
        check("R10 ch_en", {24'h0, ch_en}, 32'h08);
        wr(4'd1, 32'hFF);
        rd(4'd1, d);  check("R10 write ignored", d, 32'h08);
        @(negedge clk);
        check("R11 running", {24'h0, ch_running}, 32'h08);

        // R8 tc on ch3 raises irq
        evt_tc = 8'h08; @(posedge clk); @(negedge clk); evt_tc = '0;
        check("R8 irq on tc", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R11 halted", {24'h0, ch_running}, 32'h0);
        // R8/R4 error on ch3 suppressed, clear tc
        evt_err = 8'h08; @(posedge clk); @(negedge clk); evt_err = '0;
        wr(4'd0, 32'h00080000);
        rd(4'd0, d); check("R4 masked flag kept", d, 32'h00000008);
        check("R8 irq gated", {31'h0, irq}, 32'h0);
        wr(4'd0, 32'h00000008);
        @(negedge clk);
        check("R11 running again", {24'h0, ch_running}, 32'h08);

        // R9 abort request
        wr(4'd2, 32'h00000081);
        check("R9 abort pulse", {24'h0, abort_req}, 32'h81);
        @(negedge clk);
        check("R9 abort ends", {24'h0, abort_req}, 32'h0);
        rd(4'd2, d); check("R9 abort reads 0", d, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule